// File: doc/BRIEF.md
# Prescaled Reloadable Down-Counter Timer

This block is a programmable interval timer. A 16-bit down-counter advances once per pulse of a programmable prescaler, and the prescaler in turn counts one of two clock-enable tick inputs: a slow tick or a free-running fast tick. A control bit chooses the source. When the count runs out, the timer raises a one-cycle interrupt request. An external interrupt-enable input gates that request.

Software drives the block through a small register port that has a write strobe, a select line and a read mux. A write to the count register does two things at once: it loads the live counter and it stores the same value in a hidden period register. In auto-reload mode the counter restarts from that stored value each time it runs out. In one-shot mode it stops at zero. Reset clears the control word and the counter but leaves the period register as it was. Reset never raises an interrupt.

Top module: `reload_down_timer`

## Requirements
- R1: After reset both readback registers return 0 and irq_o stays low. Asserting reset never produces an interrupt, not even while the timer is running.
- R2: Writing the count register (wr_sel_i = 0) loads the live counter with wr_data_i, which readback with rd_sel_i = 0 returns. It also stores the same value as the reload period.
- R3: The prescale field sits in control bits [7:4]. The prescaler emits one pulse per 2^(field+1) selected ticks, so 0 gives divide-by-2 and 15 gives divide-by-65,536.
- R4: Control bit 0 enables counting. While it is set, the counter drops by one per prescaler pulse. While it is clear, the count holds its value.
- R5: With control bit 1 clear (one-shot), loading N ≥ 1 gives exactly one interrupt, on the N-th prescaler pulse. The count then stays at 0 and no further interrupt occurs until the count register is written again.
- R6: With control bit 1 set (auto-reload), an interrupt occurs on every N-th prescaler pulse, and the counter restarts from the stored period each time.
- R7: Control bit 2 selects the tick source: 0 selects slow_tick_i and 1 selects fast_tick_i. The unselected input has no effect on the count.
- R8: irq_o is a single-cycle pulse, visible in the cycle after the clock edge that takes the final prescaler pulse. It is held low whenever irq_en_i is low, and the count still expires as normal.
- R9: Loading a count of 0 while counting is enabled raises the interrupt on the next prescaler pulse.
- R10: Stopping the timer, or writing the control register with a different prescale or source, restarts the prescaler phase from zero. The next pulse then comes a full ratio later.
- R11: Readback with rd_sel_i = 1 returns the control word, with enable at bit 0, reload at bit 1, source at bit 2, the prescale field at [7:4], and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | Slow clock-enable tick source |
| fast_tick_i | input | 1 | Free-running clock-enable tick source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 count, 1 control |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 1 | Read target: 0 live count, 1 control |
| rd_data_o | output | 16 | Read data (combinational) |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The interrupt timing is checked with the fast source ticking on every cycle, across four prescale settings (divide by 2, 4, 16 and 65,536) and count values of 0, 1, 2, 3 and 10. These runs separate an off-by-one error in the prescaler from one in the counter. One-shot and reload runs with the same period show whether the period register is really used. A mid-run prescale change shows whether the phase restarts or carries over. The slow source is stepped by hand while the fast tick keeps running, which shows that only the selected input advances the timer. Runs with the interrupt masked and with reset applied mid-count separate a missing interrupt from one that is only gated.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
   // control word bit positions, fixed by the register readback layout
   localparam int unsigned CTL_RUN_BIT    = 0;
   localparam int unsigned CTL_RELOAD_BIT = 1;
   localparam int unsigned CTL_SRC_BIT    = 2;
   localparam int unsigned CTL_PS_LSB     = 4;

   typedef enum logic {
      SEL_COUNT   = 1'b0,
      SEL_CONTROL = 1'b1
   } reg_sel_e;

   typedef enum logic {
      SRC_SLOW = 1'b0,
      SRC_FAST = 1'b1
   } tick_src_e;
endpackage

// File: rtl/rdt_ctrl_reg.sv
module rdt_ctrl_reg
   import rdt_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned PS_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              run_o,
   output logic              reload_o,
   output tick_src_e         src_o,
   output logic [PS_W-1:0]   ps_o,
   output logic              phase_restart_o
);
   logic [PS_W-1:0] new_ps;
   tick_src_e       new_src;

   assign new_ps  = wr_data_i[CTL_PS_LSB +: PS_W];
   assign new_src = tick_src_e'(wr_data_i[CTL_SRC_BIT]);

   // a changed rate or source discards the partial prescaler phase
   assign phase_restart_o = wr_ctl_i && ((new_ps != ps_o) || (new_src != src_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_o    <= 1'b0;
         reload_o <= 1'b0;
         src_o    <= SRC_SLOW;
         ps_o     <= '0;
      end else if (wr_ctl_i) begin
         run_o    <= wr_data_i[CTL_RUN_BIT];
         reload_o <= wr_data_i[CTL_RELOAD_BIT];
         src_o    <= new_src;
         ps_o     <= new_ps;
      end
   end
endmodule

// File: rtl/rdt_prescaler.sv
module rdt_prescaler
   import rdt_pkg::*;
#(
   parameter int unsigned PS_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slow_tick_i,
   input  logic            fast_tick_i,
   input  tick_src_e       src_i,
   input  logic [PS_W-1:0] ps_i,
   input  logic            run_i,
   input  logic            restart_i,
   output logic            pulse_o
);
   localparam int unsigned PH_W = 2 ** PS_W;

   logic [PH_W-1:0] phase_q;
   logic [PH_W-1:0] term_mask;
   logic            tick;
   logic            at_term;

   assign tick = (src_i == SRC_FAST) ? fast_tick_i : slow_tick_i;

   // terminal phase is 2^(ps+1)-1: every bit up to and including ps set
   for (genvar i = 0; i < PH_W; i++) begin : g_mask
      assign term_mask[i] = (ps_i >= PS_W'(i));
   end

   assign at_term = (phase_q == term_mask);
   assign pulse_o = run_i && tick && at_term && !restart_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart_i || !run_i) begin
         phase_q <= '0;
      end else if (tick) begin
         phase_q <= at_term ? '0 : phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/rdt_counter.sv
module rdt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             pulse_i,
   input  logic             reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             armed_o,
   output logic             expire_o
);
   logic [CNT_W-1:0] period_q;
   logic             last_step;

   // a loaded 0 behaves like 1: it expires on the very next pulse
   assign last_step = (cnt_o <= CNT_W'(1));

   // period register deliberately has no reset
   always_ff @(posedge clk) begin
      if (load_i) period_q <= load_val_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o    <= '0;
         armed_o  <= 1'b0;
         expire_o <= 1'b0;
      end else if (load_i) begin
         cnt_o    <= load_val_i;
         armed_o  <= 1'b1;
         expire_o <= 1'b0;
      end else if (pulse_i && armed_o) begin
         if (last_step) begin
            expire_o <= 1'b1;
            cnt_o    <= reload_i ? period_q : '0;
            armed_o  <= reload_i;
         end else begin
            expire_o <= 1'b0;
            cnt_o    <= cnt_o - 1'b1;
         end
      end else begin
         expire_o <= 1'b0;
      end
   end
endmodule

// File: rtl/reload_down_timer.sv
module reload_down_timer
   import rdt_pkg::*;
#(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PS_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick_i,
   input  logic             fast_tick_i,
   input  logic             wr_en_i,
   input  logic             wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             rd_sel_i,
   output logic [CNT_W-1:0] rd_data_o,
   input  logic             irq_en_i,
   output logic             irq_o
);
   localparam int unsigned CTL_TOP = CTL_PS_LSB + PS_W;

   if (CTL_TOP > CNT_W) begin : g_bad_ctl_width
      $error("control word does not fit the data width");
   end
   if (PS_W < 1 || PS_W > 5) begin : g_bad_ps_width
      $error("prescale field width out of range");
   end

   logic             wr_cnt;
   logic             wr_ctl;
   logic             ctl_run;
   logic             ctl_reload;
   tick_src_e        ctl_src;
   logic [PS_W-1:0]  ctl_ps;
   logic             phase_restart;
   logic             pre_pulse;
   logic [CNT_W-1:0] cnt_q;
   logic             armed;
   logic             irq_raw;
   logic [CNT_W-1:0] ctl_word;

   assign wr_cnt = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_COUNT);
   assign wr_ctl = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CONTROL);

   rdt_ctrl_reg #(.DATA_W(CNT_W), .PS_W(PS_W)) u_ctl (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_ctl_i        (wr_ctl),
      .wr_data_i       (wr_data_i),
      .run_o           (ctl_run),
      .reload_o        (ctl_reload),
      .src_o           (ctl_src),
      .ps_o            (ctl_ps),
      .phase_restart_o (phase_restart)
   );

   rdt_prescaler #(.PS_W(PS_W)) u_pre (
      .clk         (clk),
      .rst_n       (rst_n),
      .slow_tick_i (slow_tick_i),
      .fast_tick_i (fast_tick_i),
      .src_i       (ctl_src),
      .ps_i        (ctl_ps),
      .run_i       (ctl_run),
      .restart_i   (phase_restart),
      .pulse_o     (pre_pulse)
   );

   rdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (wr_cnt),
      .load_val_i (wr_data_i),
      .pulse_i    (pre_pulse),
      .reload_i   (ctl_reload),
      .cnt_o      (cnt_q),
      .armed_o    (armed),
      .expire_o   (irq_raw)
   );

   always_comb begin
      ctl_word                          = '0;
      ctl_word[CTL_RUN_BIT]             = ctl_run;
      ctl_word[CTL_RELOAD_BIT]          = ctl_reload;
      ctl_word[CTL_SRC_BIT]             = ctl_src;
      ctl_word[CTL_PS_LSB +: PS_W]      = ctl_ps;
   end

   assign rd_data_o = (reg_sel_e'(rd_sel_i) == SEL_CONTROL) ? ctl_word : cnt_q;
   assign irq_o     = irq_raw && irq_en_i;
endmodule

// File: rtl/rdt_checks.sv
module rdt_checks #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_o,
   input logic             irq_en_i,
   input logic             run,
   input logic             wr_cnt,
   input logic [CNT_W-1:0] cnt,
   input logic             armed,
   input logic             irq_raw
);
   // R8: the request lasts one cycle
   a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R8: a low enable masks the request
   a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i |-> !irq_o);

   // R4: a stopped timer holds its count unless software loads it
   a_r4_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_cnt) |=> $stable(cnt));

   // R5: a disarmed counter never expires on the following edge
   a_r5_disarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !wr_cnt) |=> !irq_raw);

   // R1: reset keeps the request low
   always @(posedge clk) begin
      if (!rst_n) begin
         a_r1_quiet_in_reset: assert (!irq_o);
      end
   end
endmodule

bind reload_down_timer rdt_checks #(.CNT_W(CNT_W)) u_rdt_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_o    (irq_o),
   .irq_en_i (irq_en_i),
   .run      (ctl_run),
   .wr_cnt   (wr_cnt),
   .cnt      (cnt_q),
   .armed    (armed),
   .irq_raw  (irq_raw)
);

// File: tb/reload_down_timer_tb_top.sv
module reload_down_timer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick_i = 1'b0;
   logic        fast_tick_i = 1'b1;
   logic        wr_en_i = 1'b0;
   logic        wr_sel_i = 1'b0;
   logic [15:0] wr_data_i = '0;
   logic        rd_sel_i = 1'b0;
   logic [15:0] rd_data_o;
   logic        irq_en_i = 1'b1;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int exp_q[$];
   string exp_tag[$];
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   reload_down_timer dut_i (
      .clk(clk), .rst_n(rst_n), .slow_tick_i(slow_tick_i), .fast_tick_i(fast_tick_i),
      .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
      .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_en_i(irq_en_i), .irq_o(irq_o)
   );

   // control word helper: enable bit0, reload bit1, source bit2, prescale [7:4]
   function automatic logic [15:0] ctl(bit run, bit rel, bit fast, int ps);
      return 16'((ps & 15) << 4) | 16'({fast, rel, run});
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every observed interrupt
   always @(negedge clk) begin
      if (irq_o) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R8 unexpected irq actual=%0d expected=none", cyc);
         end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = exp_tag.pop_front();
            if (e != cyc) begin
               fails++;
               $display("FAIL %s irq cycle actual=%0d expected=%0d", t, cyc, e);
            end
         end
      end
   end

   task automatic push(string tag, int at);
      exp_q.push_back(at);
      exp_tag.push_back(tag);
   endtask

   task automatic wr(bit sel, logic [15:0] d, output int t);
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
      t = cyc;
   endtask

   task automatic rd(bit sel, output int v);
      @(negedge clk);
      rd_sel_i = sel;
      #1 v = int'(rd_data_o);
   endtask

   task automatic wait_to(int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic start(int n, logic [15:0] c, output int t0);
      int t;
      wr(1'b1, 16'h0, t);
      wr(1'b0, 16'(n), t);
      wr(1'b1, c, t0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int t0, t1, v;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(1'b0, v); check("R1 count after reset", v, 0);
      rd(1'b1, v); check("R1 control after reset", v, 0);
      check("R1 irq during reset", int'(irq_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5 R3 one-shot, divide by 2, N=3
      start(3, ctl(1, 0, 1, 0), t0);
      push("R5 one-shot", t0 + 6);
      wait_to(t0 + 14);
      rd(1'b0, v); check("R5 count stays 0", v, 0);
      check("R5 queue drained", exp_q.size(), 0);

      // R2 R4 R11 live readback and stop, divide by 8, N=10
      start(10, ctl(1, 0, 1, 2), t0);
      rd(1'b1, v); check("R11 control readback", v, 16'h0025);
      wait_to(t0 + 17);
      rd(1'b0, v); check("R2 live count", v, 8);
      wr(1'b1, ctl(0, 0, 1, 2), t1);
      wait_to(t0 + 30);
      rd(1'b0, v); check("R4 held while stopped", v, 8);

      // R6 auto-reload, divide by 4, N=2
      start(2, ctl(1, 1, 1, 1), t0);
      push("R6 reload 1", t0 + 8);
      push("R6 reload 2", t0 + 16);
      push("R6 reload 3", t0 + 24);
      wait_to(t0 + 26);
      wr(1'b1, ctl(0, 1, 1, 1), t1);
      check("R6 all reloads seen", exp_q.size(), 0);

      // R8 masked interrupt, count still expires
      irq_en_i = 1'b0;
      start(1, ctl(1, 0, 1, 0), t0);
      wait_to(t0 + 6);
      rd(1'b0, v); check("R8 masked expiry count", v, 0);
      irq_en_i = 1'b1;
      wait_to(t0 + 10);

      // R9 zero load
      start(0, ctl(1, 0, 1, 0), t0);
      push("R9 zero load", t0 + 2);
      wait_to(t0 + 8);
      check("R9 fired", exp_q.size(), 0);

      // R7 slow source selected, fast ticks ignored
      start(1, ctl(1, 0, 0, 0), t0);
      wait_to(t0 + 20);
      rd(1'b0, v); check("R7 fast ignored", v, 1);
      @(negedge clk); slow_tick_i = 1'b1;
      @(negedge clk); slow_tick_i = 1'b0;
      push("R7 slow source", cyc + 1);
      slow_tick_i = 1'b1;
      @(negedge clk); slow_tick_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 slow fired", exp_q.size(), 0);

      // R10 prescale change restarts phase
      start(1, ctl(1, 0, 1, 3), t0);
      wait_to(t0 + 10);
      wr(1'b1, ctl(1, 0, 1, 1), t1);
      push("R10 phase restart", t1 + 4);
      wait_to(t1 + 20);
      check("R10 fired", exp_q.size(), 0);

      // R3 maximum ratio 65536
      start(1, ctl(1, 0, 1, 15), t0);
      wait_to(t0 + 65530);
      rd(1'b0, v); check("R3 not yet expired", v, 1);
      push("R3 divide max", t0 + 65536);
      wait_to(t0 + 65540);
      check("R3 fired", exp_q.size(), 0);

      // R1 reset mid-run
      start(5, ctl(1, 1, 1, 0), t0);
      wait_to(t0 + 3);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rd(1'b0, v); check("R1 count after mid reset", v, 0);
      rd(1'b1, v); check("R1 control after mid reset", v, 0);
      rst_n = 1'b1;
      repeat (30) @(negedge clk);
      check("R1 no irq after reset", exp_q.size(), 0);

      finish_run();
   end
endmodule